// File: doc/BRIEF.md
# Boot Fetch Responder

This block sits on a processor's local bus during start-up and answers a short run of fetches that the processor issues toward the very top of its 20-bit address space. No memory answers them. The responder supplies the configuration straps in their place, so the processor can learn two things before it touches any real memory: the width of the system data bus, and the wake-up port setting from which it forms the address of its first control block. The processor forms that address by shifting the 16-bit strap value left by four bits. The responder serves the whole strap value and leaves the shift to the processor.

The responder only acts inside a boot window. The window opens on the first channel attention after reset and closes once the processor has completed its final strap fetch. Later channel attentions do not reopen it. Only a reset arms it again. Inside the window, each intercepted read drives the local data bus and returns a transfer acknowledge. Any address outside the reserved set is left alone: the responder does not drive the bus for it and does not acknowledge it.

The bus-width strap also sets the granularity of the answers. On a 16-bit system bus, only even word addresses are answered, with both bytes at once. On an 8-bit system bus, each reserved byte address is answered separately on the low byte lane.

Top module: `boot_fetch_responder`

## Requirements
- R1: After reset the block is armed but idle. `ack`, `data_oe` and `strap_gate` are 0 and `data_out` is 0. Reserved-address reads made before the first `chan_attn` pulse are not answered.
- R2: A read at 0xFFFF6 inside the window returns the bus-width strap on bit 0, with all other bits 0. A strap value of 1 means 16-bit and 0 means 8-bit.
- R3: Inside the window, reads at 0xFFFF8 (both modes) and 0xFFFF9 (8-bit mode only) are answered with all-zero data.
- R4: In 16-bit mode, a read at 0xFFFFA returns the full 16-bit wake strap. In 8-bit mode, 0xFFFFA returns wake strap bits 7:0 and 0xFFFFB returns bits 15:8, both on data bits 7:0 with bits 15:8 at 0. `strap_gate` is 1 exactly while such a read is being answered.
- R5: `ack` is 0 in the cycle the read strobe rises. It is 1 from the next clock edge on, for as long as the strobe is held, and it drops in the same cycle the strobe drops.
- R6: Addresses outside the reserved set are not answered: no acknowledge, no bus drive and no gate. This includes 0xFFFF7, 0xFFFFC and any non-top address, and in 16-bit mode also the odd addresses 0xFFFF9 and 0xFFFFB.
- R7: The window stays open across earlier reserved reads. It closes on the clock edge after the strobe of the final strap fetch is released (0xFFFFA in 16-bit mode, 0xFFFFB in 8-bit mode). After that no reserved read is answered, further `chan_attn` pulses have no effect, and a reset re-arms the block.
- R8: `data_out` is 0 whenever `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_attn | input | 1 | Channel attention pulse from the host |
| rd_strobe | input | 1 | Local-bus read strobe |
| fetch_addr | input | 20 | Latched fetch address |
| width_strap | input | 1 | System bus width strap: 1 for 16-bit, 0 for 8-bit |
| wake_strap | input | 16 | Wake-up port strap setting |
| data_out | output | 16 | Read data onto the local bus |
| data_oe | output | 1 | Responder drives the local data bus |
| strap_gate | output | 1 | Wake strap is gated onto the bus |
| ack | output | 1 | Transfer acknowledge |

## Verification
The boot window is exercised once with the 16-bit strap and once with the 8-bit strap, using different wake strap patterns. This shows whether word and byte answers, and the choice of byte lane, follow the mode. Reads at odd and out-of-range addresses are mixed into each run. These show whether the decode is exact and mode-aware rather than a range check. Reads are repeated before the first attention, after the final fetch and after a second attention, to separate correct window handling from a block that answers whenever it is addressed. Some strobes are held for several cycles to pin down both acknowledge edges.

// File: rtl/bfr_pkg.sv
package bfr_pkg;

    typedef enum logic [1:0] {
        PH_ARMED = 2'd0,
        PH_BOOT  = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_WIDTH = 2'd1,
        K_ZERO  = 2'd2,
        K_STRAP = 2'd3
    } kind_e;

    typedef struct packed {
        logic  hit;
        kind_e kind;
        logic  upper;
        logic  last;
    } fetch_dec_t;

    localparam fetch_dec_t DEC_MISS = '{hit: 1'b0, kind: K_NONE, upper: 1'b0, last: 1'b0};

    function automatic fetch_dec_t make_dec(input kind_e k, input logic up, input logic fin);
        fetch_dec_t d;
        d.hit   = (k != K_NONE);
        d.kind  = k;
        d.upper = up;
        d.last  = fin;
        return d;
    endfunction

endpackage

// File: rtl/bfr_decode.sv
module bfr_decode
    import bfr_pkg::*;
#(
    parameter int          ADDR_W = 20,
    parameter logic [19:0] BASE   = 20'hFFFF6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output fetch_dec_t        dec
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] TOP_A  = BASE_A + SPAN;

    logic [ADDR_W-1:0] off;
    logic              in_range;

    assign off      = addr - BASE_A;
    assign in_range = (addr >= BASE_A) && (addr <= TOP_A);

    always_comb begin
        dec = DEC_MISS;
        if (in_range) begin
            unique case (off[2:0])
                3'd0:    dec = make_dec(K_WIDTH, 1'b0, 1'b0);
                3'd2:    dec = make_dec(K_ZERO,  1'b0, 1'b0);
                3'd3:    dec = wide ? DEC_MISS : make_dec(K_ZERO, 1'b1, 1'b0);
                3'd4:    dec = make_dec(K_STRAP, 1'b0, wide);
                3'd5:    dec = wide ? DEC_MISS : make_dec(K_STRAP, 1'b1, 1'b1);
                default: dec = DEC_MISS;
            endcase
        end
    end
endmodule

// File: rtl/bfr_datasel.sv
module bfr_datasel
    import bfr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  fetch_dec_t        dec,
    input  logic              drive,
    input  logic              wide,
    input  logic              width_bit,
    input  logic [DATA_W-1:0] straps,
    output logic [DATA_W-1:0] word
);
    localparam int LANES = DATA_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_v;
        always_comb begin
            lane_v = 8'h00;
            unique case (dec.kind)
                K_WIDTH: lane_v = (g == 0) ? {7'b0, width_bit} : 8'h00;
                K_ZERO:  lane_v = 8'h00;
                K_STRAP: begin
                    if (wide)
                        lane_v = straps[g*8 +: 8];
                    else if (g == 0)
                        lane_v = dec.upper ? straps[8 +: 8] : straps[0 +: 8];
                    else
                        lane_v = 8'h00;
                end
                default: lane_v = 8'h00;
            endcase
        end
        assign word[g*8 +: 8] = drive ? lane_v : 8'h00;
    end
endmodule

// File: rtl/bfr_phase.sv
module bfr_phase
    import bfr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   attn,
    input  logic   rd,
    input  logic   serve,
    input  logic   last_fetch,
    output phase_e phase
);
    logic fin_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_ARMED;
            fin_seen <= 1'b0;
        end else begin
            unique case (phase)
                PH_ARMED: if (attn) phase <= PH_BOOT;
                PH_BOOT: begin
                    if (serve && last_fetch)
                        fin_seen <= 1'b1;
                    if (fin_seen && !rd)
                        phase <= PH_DONE;
                end
                PH_DONE:  phase <= PH_DONE;
                default:  phase <= PH_ARMED;
            endcase
        end
    end
endmodule

// File: rtl/bfr_ack.sv
module bfr_ack (
    input  logic clk,
    input  logic rst,
    input  logic rd,
    input  logic serve,
    output logic ack
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= serve;
    end

    assign ack = seen_q && rd;
endmodule

// File: rtl/boot_fetch_responder.sv
module boot_fetch_responder
    import bfr_pkg::*;
#(
    parameter int          ADDR_W = 20,
    parameter int          DATA_W = 16,
    parameter logic [19:0] BASE   = 20'hFFFF6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_attn,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              width_strap,
    input  logic [DATA_W-1:0] wake_strap,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              strap_gate,
    output logic              ack
);
    fetch_dec_t dec;
    phase_e     phase_q;
    logic       serve;

    bfr_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) i_decode (
        .addr (fetch_addr),
        .wide (width_strap),
        .dec  (dec)
    );

    assign serve      = rd_strobe && dec.hit && (phase_q == PH_BOOT);
    assign data_oe    = serve;
    assign strap_gate = serve && (dec.kind == K_STRAP);

    bfr_datasel #(.DATA_W(DATA_W)) i_datasel (
        .dec       (dec),
        .drive     (serve),
        .wide      (width_strap),
        .width_bit (width_strap),
        .straps    (wake_strap),
        .word      (data_out)
    );

    bfr_phase i_phase (
        .clk        (clk),
        .rst        (rst),
        .attn       (chan_attn),
        .rd         (rd_strobe),
        .serve      (serve),
        .last_fetch (dec.last),
        .phase      (phase_q)
    );

    bfr_ack i_ack (
        .clk   (clk),
        .rst   (rst),
        .rd    (rd_strobe),
        .serve (serve),
        .ack   (ack)
    );
endmodule

// File: rtl/bfr_checker.sv
module bfr_checker
    import bfr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_strobe,
    input logic              chan_attn,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input logic              strap_gate,
    input logic              ack,
    input phase_e            phase
);
    a_r1_reset_no_ack: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !ack);

    a_r1_armed_quiet: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ARMED) |-> !data_oe);

    a_r4_gate_with_drive: assert property (@(posedge clk) disable iff (rst)
        strap_gate |-> data_oe);

    a_r5_ack_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        ack |-> rd_strobe);

    a_r5_ack_follows_drive: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && data_oe && $past(data_oe)) |-> ack);

    a_r5_ack_late: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(rd_strobe));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE) |=> (phase == PH_DONE));

    a_r7_done_silent: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE) |-> (!data_oe && !ack));

    a_r8_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> (data_out == '0));
endmodule

bind boot_fetch_responder bfr_checker #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_strobe  (rd_strobe),
    .chan_attn  (chan_attn),
    .data_out   (data_out),
    .data_oe    (data_oe),
    .strap_gate (strap_gate),
    .ack        (ack),
    .phase      (phase_q)
);

// File: tb/test_boot_fetch_responder.sv
`timescale 1ns/1ps
module test_boot_fetch_responder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_attn = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [19:0] fetch_addr = '0;
    logic        width_strap = 1'b0;
    logic [15:0] wake_strap = '0;
    logic [15:0] data_out;
    logic        data_oe, strap_gate, ack;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    boot_fetch_responder i_boot_fetch_responder (
        .clk(clk), .rst(rst), .chan_attn(chan_attn), .rd_strobe(rd_strobe),
        .fetch_addr(fetch_addr), .width_strap(width_strap), .wake_strap(wake_strap),
        .data_out(data_out), .data_oe(data_oe), .strap_gate(strap_gate), .ack(ack)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd_strobe = 1'b0; chan_attn = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic pulse_attn();
        @(negedge clk); chan_attn = 1'b1;
        @(negedge clk); chan_attn = 1'b0;
    endtask

    // One read; hit decides whether an answer is expected.
    task automatic do_fetch(input string req, input logic [19:0] a, input logic hit,
                            input logic [15:0] exp_d, input logic gate, input int hold);
        @(negedge clk);
        fetch_addr = a; rd_strobe = 1'b1;
        #1;
        chk(req, $sformatf("oe @%h", a),   32'(data_oe), 32'(hit));
        chk(req, $sformatf("data @%h", a), 32'(data_out), 32'(hit ? exp_d : 16'h0));
        chk(req, $sformatf("gate @%h", a), 32'(strap_gate), 32'(gate));
        chk("R5", $sformatf("ack early @%h", a), 32'(ack), 32'd0);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk); #1;
            chk("R5", $sformatf("ack held @%h", a), 32'(ack), 32'(hit));
        end
        rd_strobe = 1'b0;
        #1;
        chk("R5", $sformatf("ack release @%h", a), 32'(ack), 32'd0);
        chk("R8", $sformatf("oe release @%h", a), 32'(data_oe), 32'd0);
        @(posedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1", "ack", 32'(ack), 32'd0);
        chk("R1", "oe", 32'(data_oe), 32'd0);
        chk("R1", "gate", 32'(strap_gate), 32'd0);
        chk("R1", "data", 32'(data_out), 32'd0);
    endtask

    task automatic t_before_attn();
        width_strap = 1'b1; wake_strap = 16'hA5C3;
        do_fetch("R1", 20'hFFFF6, 1'b0, 16'h0, 1'b0, 1);
        do_fetch("R1", 20'hFFFFA, 1'b0, 16'h0, 1'b0, 1);
    endtask

    task automatic t_boot_wide();
        pulse_attn();
        do_fetch("R6", 20'hFFFF7, 1'b0, 16'h0,    1'b0, 1);
        do_fetch("R2", 20'hFFFF6, 1'b1, 16'h0001, 1'b0, 3);
        do_fetch("R3", 20'hFFFF8, 1'b1, 16'h0000, 1'b0, 1);
        do_fetch("R6", 20'hFFFF9, 1'b0, 16'h0,    1'b0, 1);
        do_fetch("R6", 20'hFFFFB, 1'b0, 16'h0,    1'b0, 1);
        do_fetch("R6", 20'h0FFF6, 1'b0, 16'h0,    1'b0, 1);
        do_fetch("R4", 20'hFFFFA, 1'b1, 16'hA5C3, 1'b1, 2);
        do_fetch("R7", 20'hFFFF6, 1'b0, 16'h0,    1'b0, 1);
        pulse_attn();
        do_fetch("R7", 20'hFFFF8, 1'b0, 16'h0,    1'b0, 1);
        do_fetch("R7", 20'hFFFFA, 1'b0, 16'h0,    1'b0, 1);
    endtask

    task automatic t_boot_narrow();
        do_reset();
        width_strap = 1'b0; wake_strap = 16'h3C7E;
        do_fetch("R7", 20'hFFFF6, 1'b0, 16'h0, 1'b0, 1);
        pulse_attn();
        do_fetch("R2", 20'hFFFF6, 1'b1, 16'h0000, 1'b0, 1);
        do_fetch("R3", 20'hFFFF8, 1'b1, 16'h0000, 1'b0, 1);
        do_fetch("R3", 20'hFFFF9, 1'b1, 16'h0000, 1'b0, 2);
        do_fetch("R6", 20'h12345, 1'b0, 16'h0,    1'b0, 1);
        do_fetch("R6", 20'hFFFFC, 1'b0, 16'h0,    1'b0, 1);
        do_fetch("R4", 20'hFFFFA, 1'b1, 16'h007E, 1'b1, 1);
        do_fetch("R7", 20'hFFFF6, 1'b1, 16'h0000, 1'b0, 1);
        do_fetch("R4", 20'hFFFFB, 1'b1, 16'h003C, 1'b1, 4);
        do_fetch("R7", 20'hFFFFA, 1'b0, 16'h0,    1'b0, 1);
        do_fetch("R7", 20'hFFFFB, 1'b0, 16'h0,    1'b0, 1);
    endtask

    task automatic t_rearm_wide();
        do_reset();
        width_strap = 1'b1; wake_strap = 16'h0F1E;
        pulse_attn();
        do_fetch("R7", 20'hFFFF6, 1'b1, 16'h0001, 1'b0, 1);
        do_fetch("R4", 20'hFFFFA, 1'b1, 16'h0F1E, 1'b1, 1);
        do_fetch("R7", 20'hFFFFA, 1'b0, 16'h0,    1'b0, 1);
    endtask

    initial begin
        t_reset_state();
        t_before_attn();
        t_boot_wide();
        t_boot_narrow();
        t_rearm_wide();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule